// File: doc/BRIEF.md
# GPIO Bank with Edge-Detect Interrupts

This block holds thirty-two general-purpose pins behind a small register port. Software chooses per pin whether it is driven (direction) and drives output levels only through two write-one registers, one that raises outputs and one that lowers them. No read-modify-write cycle is ever needed. The raw pin inputs are asynchronous. They are brought into the clock domain by a two-stage synchronizer, and the synchronized value can be read back as a level word.

Each pin can record a rising edge, a falling edge or both into a sticky status word. A pin records an edge only when the matching enable bit is set. A single interrupt line is high while any status bit is set. Software clears status bits by writing ones to them. An edge that lands in the same cycle as the clear of its bit is kept, so no event is lost between read and clear. The block also stores a two-bit alternate-function code per pin and presents the codes on an output bus for the pad multiplexer.

Register offsets: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status, 7 and 8 function codes. Data words are 32 bits wide, and bit n of a word belongs to pin n.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, pin_out, pin_oe, alt_sel, irq, rdata and every readable register are zero.
- R2: Bit n of the direction register (offset 1) drives pin_oe[n] in the cycle after the write, with 1 meaning output and 0 meaning input. The register reads back as written, and pin_oe changes only on a write to offset 1.
- R3: A write to the set register (offset 2) makes pin_out[n] high for every bit n written as 1. It leaves every bit written as 0 unchanged. Offset 2 reads as zero.
- R4: A write to the clear register (offset 3) makes pin_out[n] low for every bit n written as 1. It leaves every bit written as 0 unchanged. Offset 3 reads as zero.
- R5: A read of offset 0 returns the pin inputs after two synchronizer stages. A read request at clock edge k returns the pin values sampled at edge k-2.
- R6: When rising-enable bit n (offset 4) is set, a 0-to-1 change of synchronized pin n sets status bit n (offset 6). A pin value sampled at edge k sets the status bit at edge k+2.
- R7: When falling-enable bit n (offset 5) is set, a 1-to-0 change sets status bit n. With both enables set, either edge is recorded. With neither enable set, the pin leaves its status bit unchanged.
- R8: Status bits are sticky. A bit drops only when a 1 is written to it at offset 6. Bits written as 0 are unaffected, and writing all ones clears every pending bit that has no new edge.
- R9: An enabled edge that is detected in the same cycle as a write of 1 to its status bit leaves the bit set.
- R10: irq is high exactly when at least one status bit is set.
- R11: The function code of pin p sits at offset 7 + p/16, in bits [2*(p%16)+1 : 2*(p%16)]. It appears on alt_sel[2p+1:2p] one cycle after the write, and it reads back as written.
- R12: rdata is loaded on the clock edge where rd_en is high and holds its value while rd_en is low. Unmapped offsets and the write-only offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read request; data appears on rdata after the next edge |
| addr | input | 4 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output levels |
| pin_oe | output | 32 | Output enables (1 = drive) |
| alt_sel | output | 64 | Two-bit function code per pin |
| irq | output | 1 | High while any edge-status bit is set |

## Verification
The assertions assume that rst_n deasserts away from the active edge and that each strobe names a single offset per cycle. They also assume that status bits change only through detected edges and clear writes. The stimulus keeps the pins low through reset and drives every input on the falling clock edge. It times a status clear to land on the same edge as a falling-edge detection, and it holds a read request across a pin change to pin down the two-stage latency. A behavioural model built from a sample-history queue is compared with rdata, pin_out, pin_oe, alt_sel and irq on every cycle.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  // Register offsets; the function-code words follow the base in pin order.
  localparam int unsigned OFS_LEVEL = 0;
  localparam int unsigned OFS_DIR   = 1;
  localparam int unsigned OFS_SET   = 2;
  localparam int unsigned OFS_CLR   = 3;
  localparam int unsigned OFS_RISE  = 4;
  localparam int unsigned OFS_FALL  = 5;
  localparam int unsigned OFS_STAT  = 6;
  localparam int unsigned OFS_ALT   = 7;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_async;
      stab_q <= meta_q;
    end
  end

  assign q_sync = stab_q;
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status
);
  logic [W-1:0] prev_q;
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;
  logic [W-1:0] hit;
  logic         stat_we;

  // Next state: a fresh edge wins over a clear of the same bit.
  always_comb begin
    hit     = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);
    stat_d  = (stat_q & ~clr_mask) | hit;
    stat_we = (|clr_mask) | (|hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl;
      if (stat_we) stat_q <= stat_d;
    end
  end

  assign status = stat_q;

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~$past(clr_mask)) & ~stat_q) == '0));

  // R9
  keep_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & clr_mask)) |=> (($past(hit & clr_mask) & ~stat_q) == '0));

  // R6
  set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_alt_store.sv
module gpio_alt_store #(
  parameter int unsigned NREG = 2,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 4,
  parameter int unsigned BASE = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] alt_q
);
  for (genvar r = 0; r < NREG; r++) begin : g_word
    logic          we;
    logic [DW-1:0] word_q;

    assign we = wr_en && (addr == AW'(BASE + r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '0;
      else if (we) word_q <= wdata;
    end

    assign alt_q[r*DW +: DW] = word_q;
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned FSEL_W = 2,
  parameter int unsigned AW     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [AW-1:0]           addr,
  input  logic [NPINS-1:0]        wdata,
  output logic [NPINS-1:0]        rdata,
  input  logic [NPINS-1:0]        pin_in,
  output logic [NPINS-1:0]        pin_out,
  output logic [NPINS-1:0]        pin_oe,
  output logic [NPINS*FSEL_W-1:0] alt_sel,
  output logic                    irq
);
  localparam int unsigned NALT = (NPINS * FSEL_W) / NPINS;
  localparam logic [AW-1:0] ADR_LEVEL = AW'(OFS_LEVEL);
  localparam logic [AW-1:0] ADR_DIR   = AW'(OFS_DIR);
  localparam logic [AW-1:0] ADR_SET   = AW'(OFS_SET);
  localparam logic [AW-1:0] ADR_CLR   = AW'(OFS_CLR);
  localparam logic [AW-1:0] ADR_RISE  = AW'(OFS_RISE);
  localparam logic [AW-1:0] ADR_FALL  = AW'(OFS_FALL);
  localparam logic [AW-1:0] ADR_STAT  = AW'(OFS_STAT);

  logic [NPINS-1:0] lvl_s;
  logic [NPINS-1:0] stat;
  logic [NPINS-1:0] clr_mask;
  logic [NPINS-1:0] dir_q, ren_q, fen_q, out_q, out_d, rdata_q, rd_word;
  logic             dir_we, ren_we, fen_we, out_we;
  logic [NPINS*FSEL_W-1:0] alt_q;

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(lvl_s)
  );

  gpio_edge_unit #(.W(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .rise_en(ren_q), .fall_en(fen_q),
    .clr_mask(clr_mask), .status(stat)
  );

  gpio_alt_store #(.NREG(NALT), .DW(NPINS), .AW(AW), .BASE(OFS_ALT)) u_alt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .alt_q(alt_q)
  );

  // Write decode and next state
  always_comb begin
    dir_we   = wr_en && (addr == ADR_DIR);
    ren_we   = wr_en && (addr == ADR_RISE);
    fen_we   = wr_en && (addr == ADR_FALL);
    out_we   = wr_en && ((addr == ADR_SET) || (addr == ADR_CLR));
    clr_mask = (wr_en && (addr == ADR_STAT)) ? wdata : '0;
    out_d    = (addr == ADR_SET) ? (out_q | wdata) : (out_q & ~wdata);
  end

  // Read mux
  always_comb begin
    case (addr)
      ADR_LEVEL: rd_word = lvl_s;
      ADR_DIR:   rd_word = dir_q;
      ADR_RISE:  rd_word = ren_q;
      ADR_FALL:  rd_word = fen_q;
      ADR_STAT:  rd_word = stat;
      default:   rd_word = '0;
    endcase
    for (int r = 0; r < NALT; r++) begin
      if (addr == AW'(OFS_ALT + r)) rd_word = alt_q[r*NPINS +: NPINS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      ren_q   <= '0;
      fen_q   <= '0;
      out_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (dir_we) dir_q   <= wdata;
      if (ren_we) ren_q   <= wdata;
      if (fen_we) fen_q   <= wdata;
      if (out_we) out_q   <= out_d;
      if (rd_en)  rdata_q <= rd_word;
    end
  end

  assign rdata   = rdata_q;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign alt_sel = alt_q;
  assign irq     = |stat;

  // R3
  set_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_SET) |=> ((~pin_out & $past(wdata)) == '0));

  // R4
  clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_CLR) |=> ((pin_out & $past(wdata)) == '0));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == ADR_SET || addr == ADR_CLR)) |=> $stable(pin_out));

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADR_DIR) |=> $stable(pin_oe));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata, pin_in, pin_out, pin_oe;
  logic [63:0] alt_sel;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_edge_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .alt_sel(alt_sel), .irq(irq)
  );

  // Behavioural reference model
  logic [31:0] m_dir, m_ren, m_fen, m_out, m_st, m_rd, m_hit, m_clr;
  logic [63:0] m_alt;
  logic [31:0] hist[$];  // hist[0] = newest pin sample

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0:    return hist[1];
      4'd1:    return m_dir;
      4'd4:    return m_ren;
      4'd5:    return m_fen;
      4'd6:    return m_st;
      4'd7:    return m_alt[31:0];
      4'd8:    return m_alt[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_ren = 0; m_fen = 0; m_out = 0; m_st = 0; m_rd = 0; m_alt = 0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      m_hit = (hist[1] & ~hist[2] & m_ren) | (~hist[1] & hist[2] & m_fen);
      m_clr = (wr_en && addr == 4'd6) ? wdata : 32'h0;
      if (rd_en) m_rd = m_read(addr);
      m_st = (m_st & ~m_clr) | m_hit;
      if (wr_en) begin
        case (addr)
          4'd1: m_dir = wdata;
          4'd2: m_out = m_out | wdata;
          4'd3: m_out = m_out & ~wdata;
          4'd4: m_ren = wdata;
          4'd5: m_fen = wdata;
          4'd7: m_alt[31:0]  = wdata;
          4'd8: m_alt[63:32] = wdata;
          default: ;
        endcase
      end
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rdata, m_rd, "R12 rdata vs model");
      chk(pin_out, m_out, "R3 R4 pin_out vs model");
      chk(pin_oe, m_dir, "R2 pin_oe vs model");
      chk(alt_sel, m_alt, "R11 alt_sel vs model");
      chk(irq, |m_st, "R10 irq vs model");
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = 32'h0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; pin_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pin_out, 0, "R1 pin_out"); chk(pin_oe, 0, "R1 pin_oe");
    chk(irq, 0, "R1 irq"); chk(alt_sel, 0, "R1 alt_sel"); chk(rdata, 0, "R1 rdata");
    rd(4'd1, v); chk(v, 0, "R1 dir");
    rd(4'd6, v); chk(v, 0, "R1 status");

    // R2 direction
    wr(4'd1, 32'hF0F0_00FF);
    chk(pin_oe, 32'hF0F0_00FF, "R2 pin_oe");
    rd(4'd1, v); chk(v, 32'hF0F0_00FF, "R2 readback");

    // R3 set
    wr(4'd2, 32'h0000_00A5); chk(pin_out, 32'h0000_00A5, "R3 set first");
    wr(4'd2, 32'h0000_0F00); chk(pin_out, 32'h0000_0FA5, "R3 set keeps zeros");
    rd(4'd2, v); chk(v, 0, "R3 set reads zero");

    // R4 clear
    wr(4'd3, 32'h0000_0081); chk(pin_out, 32'h0000_0F24, "R4 clear");
    wr(4'd3, 32'h0); chk(pin_out, 32'h0000_0F24, "R4 clear zeros no effect");
    rd(4'd3, v); chk(v, 0, "R4 clear reads zero");

    // R5 level and its latency
    @(negedge clk); pin_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rd(4'd0, v); chk(v, 32'h1234_5678, "R5 level");
    @(negedge clk); pin_in = 32'hAAAA_0000; rd_en = 1'b1; addr = 4'd0;
    @(negedge clk); chk(rdata, 32'h1234_5678, "R5 latency edge k");
    @(negedge clk); chk(rdata, 32'h1234_5678, "R5 latency edge k+1");
    @(negedge clk); chk(rdata, 32'hAAAA_0000, "R5 latency edge k+2");
    rd_en = 1'b0;
    pin_in = 32'h0;
    repeat (4) @(negedge clk);

    // R6 R7 edge detection; bit0 rise, bit1 both, bit2 fall, bit8 none
    wr(4'd4, 32'h3);
    wr(4'd5, 32'h6);
    @(negedge clk); pin_in = 32'h0000_0107;
    repeat (4) @(negedge clk);
    chk(irq, 1, "R10 irq after rise");
    rd(4'd6, v); chk(v, 32'h3, "R6 rising edges");
    @(negedge clk); pin_in = 32'h0;
    repeat (4) @(negedge clk);
    rd(4'd6, v); chk(v, 32'h7, "R7 falling edges, bit8 ignored");

    // R8 write-one-to-clear
    wr(4'd6, 32'h1); rd(4'd6, v); chk(v, 32'h6, "R8 clear one bit");
    wr(4'd6, 32'h0); rd(4'd6, v); chk(v, 32'h6, "R8 zeros no effect");
    wr(4'd6, 32'hFFFF_FFFF); rd(4'd6, v); chk(v, 32'h0, "R8 clear all");
    chk(irq, 0, "R10 irq low when clear");

    // R9 edge coinciding with its clear
    @(negedge clk); pin_in = 32'h2;
    repeat (4) @(negedge clk);
    @(negedge clk); pin_in = 32'h0;
    @(negedge clk);
    wr(4'd6, 32'h2);
    rd(4'd6, v); chk(v, 32'h2, "R9 edge kept over clear");
    chk(irq, 1, "R10 irq held by kept edge");
    wr(4'd6, 32'h2); rd(4'd6, v); chk(v, 32'h0, "R8 later clear takes effect");

    // R11 function codes
    wr(4'd7, 32'hC000_0003);
    wr(4'd8, 32'h0000_0008);
    chk(alt_sel[1:0], 2'd3, "R11 pin0 code");
    chk(alt_sel[31:30], 2'd3, "R11 pin15 code");
    chk(alt_sel[35:34], 2'd2, "R11 pin17 code");
    rd(4'd8, v); chk(v, 32'h0000_0008, "R11 readback");

    // R12 hold and unmapped
    rd(4'd1, v);
    wr(4'd1, 32'h0);
    repeat (2) @(negedge clk);
    chk(rdata, 32'hF0F0_00FF, "R12 rdata holds");
    rd(4'd15, v); chk(v, 0, "R12 unmapped reads zero");

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule